// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address for a single address space. It does this by reading a two-level translation table from memory, one 32-bit word at a time. A request gives the virtual address, the access kind (read or write), a base word and an address-space tag. The base word carries the frame number of the top-level directory and read, write and nonsecure attribute bits. The walker first fetches the directory entry that the top ten address bits select. If that entry points on to a page table, it fetches the page entry that the next ten bits select. It then returns either a physical address or a fault together with a cause code.

The walker handles one request at a time. While a walk is in flight it raises `busy`, and it ignores any request that arrives during that time. The memory side is a plain request/response port: the walker holds the request until the memory accepts it, and only one read is ever outstanding. The implemented physical address width is a parameter. Frame numbers read from entries are cut to that width minus 12 bits, so stray upper bits in a frame field have no effect.

Top module: `pt_walker`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `busy`, `mem_req_valid` and `resp_valid` are 0.
- R2: A request is taken only when `req_valid` is high and `busy` is low. `busy` stays high from the cycle after acceptance through the response cycle. A request that arrives while `busy` is high produces no walk and no response.
- R3: The base word gives permission by bit 31 for reads and bit 30 for writes. If the needed bit is clear, the walk ends with cause 1 and makes no memory read.
- R4: The first read goes to address (base word frame field, masked to PA_BITS-12 bits) shifted left by 12, plus va[31:22] times 4.
- R5: A directory entry whose bit 28 (points-to-table) is clear, including an all-zero entry, gives cause 2. Only the one memory read is made.
- R6: A directory entry with bit 28 set that lacks the needed permission bit (31 for reads, 30 for writes) gives cause 3, and no second read is made.
- R7: The second read goes to address (directory entry frame, masked) shifted left by 12, plus va[21:12] times 4.
- R8: A page entry equal to zero gives cause 4, meaning unmapped.
- R9: A nonzero page entry that lacks the needed permission bit (31 for reads, 30 for writes) gives cause 5.
- R10: A successful walk returns `resp_fault`=0 and cause 0. `resp_pa` is then (page entry frame, masked) shifted left by 12, ORed with va[11:0], and `resp_nonsecure` equals page entry bit 29.
- R11: On any fault, `resp_fault`=1 and `resp_pa` is 0.
- R12: `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen, and at most one read is outstanding.
- R13: `resp_valid` is a one-cycle pulse. It rises in the cycle after the edge that samples the final input of the walk (the request for a cause-1 fault, otherwise the last memory response). `resp_asid` echoes the tag that came with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| base_word | input | 32 | Directory frame number plus attribute bits 31/30/29 |
| base_asid | input | ASID_W | Address-space tag captured with the request |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | PA_BITS | Byte address of the entry word |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| resp_valid | output | 1 | Result pulse |
| resp_fault | output | 1 | Translation failed |
| resp_cause | output | 3 | 0 ok, 1 base perm, 2 not a table, 3 directory perm, 4 unmapped, 5 page perm |
| resp_pa | output | PA_BITS | Physical address, 0 on fault |
| resp_nonsecure | output | 1 | Nonsecure bit of the page entry |
| resp_asid | output | ASID_W | Tag of the answered request |

## Verification
A base-permission fault is answered one cycle after the accepting edge. Every other result is answered one cycle after the edge that takes in the final memory response. The memory model stamps the cycle of each stimulus it drives, and the bench requires the response at exactly that stamp plus one. All outputs are read on the falling edge, half a cycle clear of the edge that updates them. The addresses of the memory reads are recorded when each handshake is decided and compared against the expected directory and page entry addresses. The response fields are compared in the single cycle in which `resp_valid` is high. The cycle after that is checked for a dropped pulse and an idle walker.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    localparam int VA_W      = 32;
    localparam int IDX_W     = 10;
    localparam int OFS_W     = 12;
    localparam int BIT_RD    = 31;
    localparam int BIT_WR    = 30;
    localparam int BIT_NS    = 29;
    localparam int BIT_NEXT  = 28;

    typedef enum logic [2:0] {
        CAUSE_NONE          = 3'd0,
        CAUSE_BASE_PERM     = 3'd1,
        CAUSE_DIR_NOT_TABLE = 3'd2,
        CAUSE_DIR_PERM      = 3'd3,
        CAUSE_PAGE_UNMAPPED = 3'd4,
        CAUSE_PAGE_PERM     = 3'd5
    } cause_e;

    typedef enum logic [1:0] {
        CHK_BASE,
        CHK_DIR,
        CHK_PAGE
    } chk_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_PAGE_REQ,
        ST_PAGE_WAIT,
        ST_RESP
    } walk_state_e;

    function automatic logic [IDX_W-1:0] dir_index(input logic [VA_W-1:0] va);
        return va[31:22];
    endfunction

    function automatic logic [IDX_W-1:0] page_index(input logic [VA_W-1:0] va);
        return va[21:12];
    endfunction

    function automatic logic [OFS_W-1:0] word_offset(input logic [IDX_W-1:0] idx);
        return {idx, 2'b00};
    endfunction

    function automatic logic access_allowed(input logic [31:0] entry, input logic is_write);
        return is_write ? entry[BIT_WR] : entry[BIT_RD];
    endfunction

endpackage

// File: rtl/pt_frame_addr.sv
module pt_frame_addr #(
    parameter int PA_BITS = 34,
    localparam int FRAME_W = PA_BITS - 12
) (
    input  logic [FRAME_W-1:0] frame,
    input  logic [11:0]        offset,
    output logic [PA_BITS-1:0] addr
);
    assign addr = {frame, 12'h000} + {{FRAME_W{1'b0}}, offset};
endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
    import pt_walker_pkg::*;
#(
    parameter chk_kind_e KIND = CHK_PAGE
) (
    input  logic [31:0] entry,
    input  logic        is_write,
    output cause_e      cause
);
    logic perm_ok;
    assign perm_ok = access_allowed(entry, is_write);

    generate
        if (KIND == CHK_BASE) begin : g_base
            logic unused_base;
            assign unused_base = ^entry[29:0];
            always_comb cause = perm_ok ? CAUSE_NONE : CAUSE_BASE_PERM;
        end else if (KIND == CHK_DIR) begin : g_dir
            logic unused_dir;
            assign unused_dir = ^{entry[BIT_NS], entry[27:0]};
            always_comb begin
                if (!entry[BIT_NEXT])
                    cause = CAUSE_DIR_NOT_TABLE;
                else if (!perm_ok)
                    cause = CAUSE_DIR_PERM;
                else
                    cause = CAUSE_NONE;
            end
        end else begin : g_page
            always_comb begin
                if (entry == 32'h0)
                    cause = CAUSE_PAGE_UNMAPPED;
                else if (!perm_ok)
                    cause = CAUSE_PAGE_PERM;
                else
                    cause = CAUSE_NONE;
            end
        end
    endgenerate
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int PA_BITS = 34,
    parameter int ASID_W  = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [31:0]        req_va,
    input  logic               req_write,
    input  logic [31:0]        base_word,
    input  logic [ASID_W-1:0]  base_asid,
    output logic               busy,
    output logic               mem_req_valid,
    output logic [PA_BITS-1:0] mem_req_addr,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    input  logic [31:0]        mem_rsp_data,
    output logic               resp_valid,
    output logic               resp_fault,
    output logic [2:0]         resp_cause,
    output logic [PA_BITS-1:0] resp_pa,
    output logic               resp_nonsecure,
    output logic [ASID_W-1:0]  resp_asid
);
    localparam int FRAME_W = PA_BITS - 12;

    walk_state_e          state_q;
    logic [VA_W-1:0]      va_q;
    logic                 wr_q;
    logic [ASID_W-1:0]    asid_q;
    logic [FRAME_W-1:0]   dir_frame_q;
    logic [FRAME_W-1:0]   page_frame_q;
    logic                 res_fault_q;
    cause_e               res_cause_q;
    logic [PA_BITS-1:0]   res_pa_q;
    logic                 res_ns_q;

    cause_e               base_cause, dir_cause, page_cause;
    logic [PA_BITS-1:0]   dir_entry_addr, page_entry_addr, pa_next;

    pt_entry_check #(.KIND(CHK_BASE)) u_base_chk (
        .entry(base_word), .is_write(req_write), .cause(base_cause));
    pt_entry_check #(.KIND(CHK_DIR)) u_dir_chk (
        .entry(mem_rsp_data), .is_write(wr_q), .cause(dir_cause));
    pt_entry_check #(.KIND(CHK_PAGE)) u_page_chk (
        .entry(mem_rsp_data), .is_write(wr_q), .cause(page_cause));

    pt_frame_addr #(.PA_BITS(PA_BITS)) u_dir_addr (
        .frame(dir_frame_q), .offset(word_offset(dir_index(va_q))), .addr(dir_entry_addr));
    pt_frame_addr #(.PA_BITS(PA_BITS)) u_page_addr (
        .frame(page_frame_q), .offset(word_offset(page_index(va_q))), .addr(page_entry_addr));
    pt_frame_addr #(.PA_BITS(PA_BITS)) u_pa (
        .frame(mem_rsp_data[FRAME_W-1:0]), .offset(va_q[OFS_W-1:0]), .addr(pa_next));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            va_q         <= '0;
            wr_q         <= 1'b0;
            asid_q       <= '0;
            dir_frame_q  <= '0;
            page_frame_q <= '0;
            res_fault_q  <= 1'b0;
            res_cause_q  <= CAUSE_NONE;
            res_pa_q     <= '0;
            res_ns_q     <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q        <= req_va;
                        wr_q        <= req_write;
                        asid_q      <= base_asid;
                        dir_frame_q <= base_word[FRAME_W-1:0];
                        res_pa_q    <= '0;
                        res_ns_q    <= 1'b0;
                        if (base_cause != CAUSE_NONE) begin
                            res_fault_q <= 1'b1;
                            res_cause_q <= base_cause;
                            state_q     <= ST_RESP;
                        end else begin
                            res_fault_q <= 1'b0;
                            res_cause_q <= CAUSE_NONE;
                            state_q     <= ST_DIR_REQ;
                        end
                    end
                end
                ST_DIR_REQ: begin
                    if (mem_req_ready) state_q <= ST_DIR_WAIT;
                end
                ST_DIR_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (dir_cause != CAUSE_NONE) begin
                            res_fault_q <= 1'b1;
                            res_cause_q <= dir_cause;
                            state_q     <= ST_RESP;
                        end else begin
                            page_frame_q <= mem_rsp_data[FRAME_W-1:0];
                            state_q      <= ST_PAGE_REQ;
                        end
                    end
                end
                ST_PAGE_REQ: begin
                    if (mem_req_ready) state_q <= ST_PAGE_WAIT;
                end
                ST_PAGE_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (page_cause != CAUSE_NONE) begin
                            res_fault_q <= 1'b1;
                            res_cause_q <= page_cause;
                        end else begin
                            res_pa_q <= pa_next;
                            res_ns_q <= mem_rsp_data[BIT_NS];
                        end
                        state_q <= ST_RESP;
                    end
                end
                ST_RESP: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy           = (state_q != ST_IDLE);
    assign mem_req_valid  = (state_q == ST_DIR_REQ) || (state_q == ST_PAGE_REQ);
    assign mem_req_addr   = (state_q == ST_PAGE_REQ) ? page_entry_addr : dir_entry_addr;
    assign resp_valid     = (state_q == ST_RESP);
    assign resp_fault     = res_fault_q;
    assign resp_cause     = res_cause_q;
    assign resp_pa        = res_pa_q;
    assign resp_nonsecure = res_ns_q;
    assign resp_asid      = asid_q;

    // R12
    mem_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R13
    resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    // R11
    fault_pa_zero_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid && resp_fault |-> resp_pa == '0);

    // R2
    req_under_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> busy);

    // R3
    base_fault_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) && resp_valid |-> resp_cause == 3'd1 && !mem_req_valid);

    // R12
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rsp_valid && (state_q == ST_DIR_WAIT || state_q == ST_PAGE_WAIT) |=> !resp_valid || !mem_req_valid);
endmodule

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
    localparam int PA = 34;
    localparam int FW = PA - 12;

    logic clk = 0;
    logic rst = 1;
    logic req_valid = 0;
    logic [31:0] req_va = 0;
    logic req_write = 0;
    logic [31:0] base_word = 0;
    logic [6:0] base_asid = 0;
    logic busy, mem_req_valid, mem_req_ready = 0, mem_rsp_valid = 0;
    logic [PA-1:0] mem_req_addr;
    logic [31:0] mem_rsp_data = 0;
    logic resp_valid, resp_fault, resp_nonsecure;
    logic [2:0] resp_cause;
    logic [PA-1:0] resp_pa;
    logic [6:0] resp_asid;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int last_drive = 0;
    int rd_count = 0;
    logic [63:0] rd_addr [0:3];
    logic [31:0] mem [logic [63:0]];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pt_walker #(.PA_BITS(PA), .ASID_W(7)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
        .req_write(req_write), .base_word(base_word), .base_asid(base_asid),
        .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .resp_valid(resp_valid), .resp_fault(resp_fault),
        .resp_cause(resp_cause), .resp_pa(resp_pa), .resp_nonsecure(resp_nonsecure),
        .resp_asid(resp_asid));

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rdmem(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [63:0] fbase(input logic [31:0] e);
        return ({32'h0, e} & ((64'd1 << FW) - 64'd1)) << 12;
    endfunction

    function automatic logic permit(input logic [31:0] e, input logic wr);
        return wr ? e[30] : e[31];
    endfunction

    task automatic predict(input logic [31:0] va, input logic wr, input logic [31:0] base,
                           output logic [2:0] cause, output logic [63:0] pa, output logic ns,
                           output int nrd, output logic [63:0] a0, output logic [63:0] a1);
        logic [31:0] pde, pte;
        cause = 0; pa = 0; ns = 0; nrd = 0; a0 = 0; a1 = 0;
        if (!permit(base, wr)) begin cause = 1; return; end
        a0 = fbase(base) + {54'h0, va[31:22], 2'b00};
        nrd = 1;
        pde = rdmem(a0);
        if (!pde[28]) begin cause = 2; return; end
        if (!permit(pde, wr)) begin cause = 3; return; end
        a1 = fbase(pde) + {54'h0, va[21:12], 2'b00};
        nrd = 2;
        pte = rdmem(a1);
        if (pte == 0) begin cause = 4; return; end
        if (!permit(pte, wr)) begin cause = 5; return; end
        pa = fbase(pte) | {52'h0, va[11:0]};
        ns = pte[29];
    endtask

    // memory model: decides handshakes at falling edges, answers 1..3 cycles later
    initial begin
        bit pending = 0;
        int dly = 0;
        logic [63:0] paddr = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 0;
            if (rst) begin
                pending = 0;
                mem_req_ready = 0;
            end else if (pending) begin
                mem_req_ready = 0;
                if (dly == 0) begin
                    mem_rsp_valid = 1;
                    mem_rsp_data = rdmem(paddr);
                    last_drive = cyc;
                    pending = 0;
                end else dly--;
            end else begin
                mem_req_ready = ($urandom_range(0, 2) != 0);
                if (mem_req_valid && mem_req_ready) begin
                    pending = 1;
                    paddr = {30'h0, mem_req_addr};
                    dly = $urandom_range(0, 2);
                    if (rd_count < 4) rd_addr[rd_count] = paddr;
                    rd_count++;
                end
            end
        end
    end

    task automatic setup(input logic [31:0] base, input logic [31:0] va,
                         input logic [31:0] pde, input logic [31:0] pte);
        logic [63:0] da, ta;
        mem.delete();
        da = fbase(base) + {54'h0, va[31:22], 2'b00};
        ta = fbase(pde) + {54'h0, va[21:12], 2'b00};
        mem[ta] = pte;
        mem[da] = pde;
    endtask

    task automatic run_txn(input logic [31:0] va, input logic wr, input logic [31:0] base,
                           input logic [6:0] asid, input bit intrude, input string tag);
        logic [2:0] ec; logic [63:0] epa; logic ens; int enr; logic [63:0] ea0, ea1;
        int waited;
        predict(va, wr, base, ec, epa, ens, enr, ea0, ea1);
        @(negedge clk);
        rd_count = 0;
        req_valid = 1; req_va = va; req_write = wr; base_word = base; base_asid = asid;
        last_drive = cyc;
        @(negedge clk);
        req_valid = 0;
        chk("R2", {tag, " busy after accept"}, {63'h0, busy}, 64'd1);
        if (intrude && !resp_valid) begin
            req_valid = 1; req_va = ~va; req_write = ~wr; base_asid = ~asid;
        end
        waited = 0;
        while (!resp_valid && waited < 300) begin
            @(negedge clk);
            waited++;
            req_valid = 0;
        end
        req_valid = 0;
        if (!resp_valid) begin
            chk("R13", {tag, " response timeout"}, 64'd0, 64'd1);
            return;
        end
        chk("R13", {tag, " latency"}, cyc, last_drive + 1);
        chk("R13", {tag, " asid echo"}, {57'h0, resp_asid}, {57'h0, asid});
        case (ec)
            3'd1: chk("R3", {tag, " cause"}, {61'h0, resp_cause}, {61'h0, ec});
            3'd2: chk("R5", {tag, " cause"}, {61'h0, resp_cause}, {61'h0, ec});
            3'd3: chk("R6", {tag, " cause"}, {61'h0, resp_cause}, {61'h0, ec});
            3'd4: chk("R8", {tag, " cause"}, {61'h0, resp_cause}, {61'h0, ec});
            3'd5: chk("R9", {tag, " cause"}, {61'h0, resp_cause}, {61'h0, ec});
            default: chk("R10", {tag, " cause"}, {61'h0, resp_cause}, 64'd0);
        endcase
        if (ec != 0) begin
            chk("R11", {tag, " fault flag"}, {63'h0, resp_fault}, 64'd1);
            chk("R11", {tag, " pa zero"}, {30'h0, resp_pa}, 64'd0);
        end else begin
            chk("R10", {tag, " fault flag"}, {63'h0, resp_fault}, 64'd0);
            chk("R10", {tag, " pa"}, {30'h0, resp_pa}, epa);
            chk("R10", {tag, " nonsecure"}, {63'h0, resp_nonsecure}, {63'h0, ens});
        end
        chk("R12", {tag, " read count"}, rd_count, enr);
        if (enr >= 1) chk("R4", {tag, " directory addr"}, rd_addr[0], ea0);
        if (enr >= 2) chk("R7", {tag, " table addr"}, rd_addr[1], ea1);
        @(negedge clk);
        chk("R13", {tag, " pulse ends"}, {63'h0, resp_valid}, 64'd0);
        chk("R2", {tag, " idle after"}, {63'h0, busy}, 64'd0);
        if (intrude) begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                chk("R2", {tag, " no second walk"}, {62'h0, busy, resp_valid}, 64'd0);
            end
        end
    endtask

    task automatic random_case(input int n);
        logic [31:0] va, base, pde, pte;
        logic wr;
        int r;
        va = $urandom; wr = $urandom_range(0, 1);
        base = $urandom;
        base[31:30] = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(0, 3)) : 2'b11;
        pde = $urandom;
        r = $urandom_range(0, 9);
        if (r == 0) pde = 0;
        else if (r == 1) pde[28] = 0;
        else if (r == 2) begin pde[28] = 1; pde[31:30] = wr ? 2'b10 : 2'b01; end
        else begin pde[28] = 1; pde[31:30] = 2'b11; end
        pte = $urandom;
        r = $urandom_range(0, 9);
        if (r == 0) pte = 0;
        else if (r == 1) pte[31:30] = wr ? 2'b10 : 2'b01;
        else pte[31:30] = 2'b11;
        setup(base, va, pde, pte);
        run_txn(va, wr, base, 7'($urandom), (n % 17) == 0, "random");
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", {63'h0, busy}, 64'd0);
        chk("R1", "mem req in reset", {63'h0, mem_req_valid}, 64'd0);
        rst = 0;
        @(negedge clk);
        chk("R1", "resp after reset", {63'h0, resp_valid}, 64'd0);
        chk("R1", "busy after reset", {63'h0, busy}, 64'd0);

        // R10 read and write success
        setup(32'hE000_1234, 32'h1234_5678, 32'hF000_0042, 32'hE000_0777);
        run_txn(32'h1234_5678, 0, 32'hE000_1234, 7'h11, 0, "read ok");
        run_txn(32'h1234_5678, 1, 32'hE000_1234, 7'h12, 0, "write ok");
        // R3 base lacks write / read
        run_txn(32'h1234_5678, 1, 32'hA000_1234, 7'h13, 0, "base no write");
        run_txn(32'h1234_5678, 0, 32'h6000_1234, 7'h14, 0, "base no read");
        // R5 zero directory entry and no next-level flag
        setup(32'hE000_0010, 32'h8000_0000, 32'h0, 32'h0);
        run_txn(32'h8000_0000, 0, 32'hE000_0010, 7'h15, 0, "pde zero");
        setup(32'hE000_0010, 32'h8000_0000, 32'hE000_0020, 32'hC000_0001);
        run_txn(32'h8000_0000, 0, 32'hE000_0010, 7'h16, 0, "pde no next");
        // R6 directory entry lacks write
        setup(32'hE000_0010, 32'h8040_0000, 32'hB000_0020, 32'hC000_0001);
        run_txn(32'h8040_0000, 1, 32'hE000_0010, 7'h17, 0, "pde no write");
        // R8 unmapped page
        setup(32'hE000_0010, 32'h0000_1000, 32'hF000_0020, 32'h0);
        run_txn(32'h0000_1000, 0, 32'hE000_0010, 7'h18, 0, "pte zero");
        // R9 read-only page written
        setup(32'hE000_0010, 32'h0000_1000, 32'hF000_0020, 32'hA000_0099);
        run_txn(32'h0000_1000, 1, 32'hE000_0010, 7'h19, 0, "pte read only");
        // R4 R7 R10 junk above the implemented frame width, all-ones address
        setup(32'hEFC0_0003, 32'hFFFF_FFFF, 32'hDFC0_0005, 32'hCFFF_FFFF);
        run_txn(32'hFFFF_FFFF, 0, 32'hEFC0_0003, 7'h7F, 0, "frame mask");
        // R2 request while busy is ignored
        setup(32'hE000_0010, 32'h0040_2000, 32'hF000_0030, 32'hE000_0123);
        run_txn(32'h0040_2000, 0, 32'hE000_0010, 7'h05, 1, "busy ignore");

        for (int n = 0; n < 300; n++) random_case(n);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule